// File: doc/BRIEF.md
# Accumulator ALU with Flag Nibble

This block is the arithmetic and logic unit of a small accumulator machine. Each cycle it takes the accumulator value, a second operand, a four-bit operation code and the current condition flags (zero, subtract, half-carry, carry), and computes an 8-bit result together with the new flags. The outputs are registered, so they appear one clock after the inputs are sampled.

A write-enable output tells the surrounding datapath whether the result should be stored. Compare, set-carry, complement-carry and the two unused codes change only the flags. The flag byte holds zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4, and its lower nibble is always 0. The incoming flag nibble uses the same order: zero in bit 3 down to carry in bit 0.

Top module: `alu_core`

## Requirements
- R1: While `rst_n` is low, `result_o`, `flags_o` and `wr_en_o` are all 0.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge and hold steady between edges. The flag byte is {zero, subtract, half-carry, carry, 4'b0000}. `flags_i` is {zero, subtract, half-carry, carry}.
- R3: Code 0 (add) and code 1 (add with incoming carry) return (acc + opb [+ carry]) mod 256 with write enabled. Carry is bit 8 of the sum, half-carry is the carry out of bit 3, subtract is 0 and zero is set for a 0 result.
- R4: Code 2 (subtract) and code 3 (subtract with incoming carry as borrow) return (acc − opb [− carry]) mod 256 with write enabled. Carry is the borrow out of bit 7, half-carry is the borrow out of bit 3, subtract is 1 and zero is set for a 0 result.
- R5: Code 7 (compare) sets the flags exactly as code 2 does, returns the accumulator unchanged and keeps write disabled.
- R6: Code 4 (AND) sets half-carry and clears subtract and carry. Code 5 (XOR) and code 6 (OR) clear half-carry, subtract and carry. All three set zero from the result and enable write.
- R7: Code 8 increments opb and code 9 decrements it, with write enabled and the accumulator ignored. Both keep the incoming carry. Increment clears subtract and sets half-carry when the result's low nibble is 0. Decrement sets subtract and sets half-carry when the result's low nibble is 0xF.
- R8: Code 10 (decimal adjust) applies a correction to the accumulator. The correction includes 0x06 when the incoming half-carry is set or the low nibble exceeds 9. It includes 0x60 when the incoming carry is set or the accumulator exceeds 0x99. The correction is subtracted when the incoming subtract flag is set and added otherwise. The new carry records whether 0x60 was applied, half-carry is cleared, subtract is kept, zero follows the result, and write is enabled.
- R9: Code 11 returns the inverted accumulator with write enabled. It sets subtract and half-carry and keeps zero and carry.
- R10: Code 12 forces carry to 1 and code 13 inverts carry. Both clear subtract and half-carry, keep zero, return the accumulator and keep write disabled.
- R11: Codes 14 and 15 keep write disabled, return the accumulator and pass the incoming flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | DATA_W | Accumulator operand |
| opb_i | input | DATA_W | Second operand, also the source for increment and decrement |
| flags_i | input | 4 | Incoming flags {zero, subtract, half-carry, carry} |
| result_o | output | DATA_W | Registered result |
| flags_o | output | 8 | Registered flag byte |
| wr_en_o | output | 1 | Registered destination write enable |

## Verification
The bench uses the default width, DATA_W = 8. At this width, every operand pair for plain add and plain subtract fits within the run, which covers every nibble-carry and borrow case. Decimal adjust is swept over all 256 accumulator values under all sixteen incoming flag combinations, so every pair of low and high correction decisions is reached in both directions. The remaining codes are run against strided operand sets with incoming flags set to all ones and to all zeros, which shows which flags are overwritten and which are kept.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_XOR = 4'd5,
        OP_OR  = 4'd6,
        OP_CP  = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_DAA = 4'd10,
        OP_CPL = 4'd11,
        OP_SCF = 4'd12,
        OP_CCF = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } alu_flags_t;

    localparam int NIB_W = 4;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              hout_o
);
    localparam int NW   = alu_pkg::NIB_W;
    localparam int HI_W = DATA_W - NW;

    logic [DATA_W-1:0] b_eff;
    logic              c0;
    logic [NW:0]       lo_sum;
    logic [HI_W:0]     hi_sum;

    // Subtraction as a + ~b + ~borrow; carries are flipped back into borrows.
    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        c0     = sub_i ? ~cin_i : cin_i;
        lo_sum = {1'b0, a_i[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, c0};
        hi_sum = {1'b0, a_i[DATA_W-1:NW]} + {1'b0, b_eff[DATA_W-1:NW]}
               + {{HI_W{1'b0}}, lo_sum[NW]};
        sum_o  = {hi_sum[HI_W-1:0], lo_sum[NW-1:0]};
        cout_o = hi_sum[HI_W] ^ sub_i;
        hout_o = lo_sum[NW] ^ sub_i;
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        sel_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        unique case (sel_i)
            2'd0:    res_o = a_i & b_i;
            2'd1:    res_o = a_i ^ b_i;
            default: res_o = a_i | b_i;
        endcase
    end
endmodule

// File: rtl/alu_bcd_adj.sv
module alu_bcd_adj #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              n_i,
    input  logic              h_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);
    localparam int NW = alu_pkg::NIB_W;
    localparam logic [NW-1:0]     LO_LIM  = NW'(9);
    localparam logic [DATA_W-1:0] HI_LIM  = DATA_W'(8'h99);
    localparam logic [DATA_W-1:0] LO_CORR = DATA_W'(8'h06);
    localparam logic [DATA_W-1:0] HI_CORR = DATA_W'(8'h60);

    logic              lo_fix;
    logic              hi_fix;
    logic [DATA_W-1:0] corr;

    always_comb begin
        lo_fix = h_i | (a_i[NW-1:0] > LO_LIM);
        hi_fix = c_i | (a_i > HI_LIM);
        corr   = (lo_fix ? LO_CORR : '0) | (hi_fix ? HI_CORR : '0);
        res_o  = n_i ? (a_i - corr) : (a_i + corr);
        cout_o = hi_fix;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [3:0]        flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [7:0]        flags_o,
    output logic              wr_en_o
);
    import alu_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        alu_flags_t        fl;
        logic              we;
    } alu_state_t;

    alu_state_t state_d, state_q;
    alu_flags_t fin;
    alu_op_e    op;

    logic [DATA_W-1:0] as_a, as_b, as_sum;
    logic              as_cin, as_sub, as_cout, as_hout;
    logic [DATA_W-1:0] lg_res;
    logic [DATA_W-1:0] bcd_res;
    logic              bcd_cout;

    assign fin = alu_flags_t'(flags_i);
    assign op  = alu_op_e'(op_i);

    // Operand steering for the shared adder/subtractor
    always_comb begin
        as_a   = acc_i;
        as_b   = opb_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC:        as_cin = fin.c;
            OP_SUB, OP_CP: as_sub = 1'b1;
            OP_SBC: begin
                as_cin = fin.c;
                as_sub = 1'b1;
            end
            OP_INC: begin
                as_a = opb_i;
                as_b = ONE;
            end
            OP_DEC: begin
                as_a   = opb_i;
                as_b   = ONE;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i    (as_a),
        .b_i    (as_b),
        .cin_i  (as_cin),
        .sub_i  (as_sub),
        .sum_o  (as_sum),
        .cout_o (as_cout),
        .hout_o (as_hout)
    );

    alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i   (acc_i),
        .b_i   (opb_i),
        .sel_i (op_i[1:0]),
        .res_o (lg_res)
    );

    alu_bcd_adj #(.DATA_W(DATA_W)) u_bcd (
        .a_i    (acc_i),
        .n_i    (fin.n),
        .h_i    (fin.h),
        .c_i    (fin.c),
        .res_o  (bcd_res),
        .cout_o (bcd_cout)
    );

    always_comb begin
        state_d.res = acc_i;
        state_d.fl  = fin;
        state_d.we  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                state_d.res = as_sum;
                state_d.fl  = '{z: (as_sum == '0), n: 1'b0, h: as_hout, c: as_cout};
                state_d.we  = 1'b1;
            end
            OP_SUB, OP_SBC: begin
                state_d.res = as_sum;
                state_d.fl  = '{z: (as_sum == '0), n: 1'b1, h: as_hout, c: as_cout};
                state_d.we  = 1'b1;
            end
            OP_CP: begin
                state_d.fl  = '{z: (as_sum == '0), n: 1'b1, h: as_hout, c: as_cout};
            end
            OP_AND, OP_XOR, OP_OR: begin
                state_d.res = lg_res;
                state_d.fl  = '{z: (lg_res == '0), n: 1'b0, h: (op == OP_AND), c: 1'b0};
                state_d.we  = 1'b1;
            end
            OP_INC: begin
                state_d.res = as_sum;
                state_d.fl  = '{z: (as_sum == '0), n: 1'b0, h: as_hout, c: fin.c};
                state_d.we  = 1'b1;
            end
            OP_DEC: begin
                state_d.res = as_sum;
                state_d.fl  = '{z: (as_sum == '0), n: 1'b1, h: as_hout, c: fin.c};
                state_d.we  = 1'b1;
            end
            OP_DAA: begin
                state_d.res = bcd_res;
                state_d.fl  = '{z: (bcd_res == '0), n: fin.n, h: 1'b0, c: bcd_cout};
                state_d.we  = 1'b1;
            end
            OP_CPL: begin
                state_d.res = ~acc_i;
                state_d.fl  = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
                state_d.we  = 1'b1;
            end
            OP_SCF: state_d.fl = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
            OP_CCF: state_d.fl = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.res;
    assign flags_o  = {state_q.fl, 4'b0000};
    assign wr_en_o  = state_q.we;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [3:0]        flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [7:0]        flags_o,
    input logic              wr_en_o
);
    import alu_pkg::*;

    // High when the previous rising edge saw reset released
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_add_clears_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_i) == OP_ADD || $past(op_i) == OP_ADC)
        |-> !flags_o[6] && wr_en_o);

    assert_sub_sets_n_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_i) == OP_SUB || $past(op_i) == OP_SBC)
        |-> flags_o[6] && wr_en_o);

    assert_cp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_CP
        |-> result_o == $past(acc_i) && !wr_en_o && flags_o[6]);

    assert_and_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_AND |-> flags_o[6:4] == 3'b010);

    assert_incdec_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)
        |-> flags_o[4] == $past(flags_i[0]));

    assert_cpl_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_CPL
        |-> flags_o[6:5] == 2'b11 && result_o == ~$past(acc_i));

    assert_scf_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) == OP_SCF |-> flags_o[6:4] == 3'b001 && !wr_en_o);

    assert_unused_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(op_i) >= 4'd14
        |-> !wr_en_o && flags_o[7:4] == $past(flags_i));
endmodule

bind alu_core alu_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .flags_i  (flags_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/alu_core_bench.sv
module alu_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opb_i = '0;
    logic [3:0] flags_i = '0;
    logic [7:0] result_o;
    logic [7:0] flags_o;
    logic       wr_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    alu_core u_alu_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (op_i),
        .acc_i    (acc_i),
        .opb_i    (opb_i),
        .flags_i  (flags_i),
        .result_o (result_o),
        .flags_o  (flags_o),
        .wr_en_o  (wr_en_o)
    );

    // Reference: returns {result, flag byte, write enable}
    function automatic logic [16:0] ref_alu(int op, int a, int b, int f);
        int z = (f >> 3) & 1, n = (f >> 2) & 1, h = (f >> 1) & 1, c = f & 1;
        int r = a, ci, t, corr, we = 0;
        bit lo, hi;
        case (op)
            0, 1: begin
                ci = (op == 1) ? c : 0;
                t = a + b + ci;
                r = t & 255; n = 0; c = (t > 255);
                h = (((a & 15) + (b & 15) + ci) > 15); z = (r == 0); we = 1;
            end
            2, 3, 7: begin
                ci = (op == 3) ? c : 0;
                t = a - b - ci;
                c = (t < 0); n = 1;
                h = (((a & 15) - (b & 15) - ci) < 0); z = ((t & 255) == 0);
                if (op != 7) begin r = t & 255; we = 1; end
            end
            4, 5, 6: begin
                r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
                z = (r == 0); n = 0; c = 0; h = (op == 4); we = 1;
            end
            8: begin r = (b + 1) & 255; z = (r == 0); n = 0; h = ((r & 15) == 0); we = 1; end
            9: begin r = (b + 255) & 255; z = (r == 0); n = 1; h = ((r & 15) == 15); we = 1; end
            10: begin
                lo = (h != 0) || ((a & 15) > 9);
                hi = (c != 0) || (a > 153);
                corr = (lo ? 6 : 0) + (hi ? 96 : 0);
                r = (n != 0) ? ((a - corr) & 255) : ((a + corr) & 255);
                z = (r == 0); h = 0; c = hi; we = 1;
            end
            11: begin r = (~a) & 255; n = 1; h = 1; we = 1; end
            12: begin c = 1; n = 0; h = 0; end
            13: begin c = 1 - c; n = 0; h = 0; end
            default: ;
        endcase
        return {8'(r), z[0], n[0], h[0], c[0], 4'b0000, we[0]};
    endfunction

    // One vector per cycle; R2: result sampled one edge after the inputs
    task automatic run_vec(input int op, input int a, input int b, input int f, input string tag);
        logic [16:0] exp;
        op_i = 4'(op); acc_i = 8'(a); opb_i = 8'(b); flags_i = 4'(f);
        @(negedge clk);
        exp = ref_alu(op, a, b, f);
        n_checks++;
        if ({result_o, flags_o, wr_en_o} !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%02h b=%02h f=%h: got res=%02h fl=%02h we=%b exp res=%02h fl=%02h we=%b",
                     tag, op, a, b, f, result_o, flags_o, wr_en_o, exp[16:9], exp[8:1], exp[0]);
        end
    endtask

    task automatic check_raw(input logic [16:0] exp, input string tag);
        n_checks++;
        if ({result_o, flags_o, wr_en_o} !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%02h fl=%02h we=%b exp res=%02h fl=%02h we=%b",
                     tag, result_o, flags_o, wr_en_o, exp[16:9], exp[8:1], exp[0]);
        end
    endtask

    task automatic t_reset();
        op_i = 4'd11; acc_i = 8'h00; flags_i = 4'hF;
        repeat (3) @(negedge clk);
        check_raw(17'h0, "R1 reset");
        rst_n = 1'b1;
    endtask

    task automatic t_latency();
        run_vec(0, 8'h01, 8'h01, 0, "R2 latency");
        op_i = 4'd11; acc_i = 8'h00; flags_i = 4'h0;
        #2;
        check_raw({8'h02, 8'h00, 1'b1}, "R2 hold between edges");
        @(negedge clk);
        check_raw({8'hFF, 8'h60, 1'b1}, "R2 next edge");
    endtask

    task automatic t_add();
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                run_vec(0, a, b, (a ^ b) & 15, "R3 add");
        for (int a = 0; a < 256; a++) begin
            run_vec(1, a, (a * 7 + 3) & 255, 1, "R3 adc");
            run_vec(1, a, 255 - a, 14, "R3 adc");
            run_vec(1, a, 255 - a, 1, "R3 adc");
        end
    endtask

    task automatic t_sub();
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                run_vec(2, a, b, (a + b) & 15, "R4 sub");
        for (int a = 0; a < 256; a++) begin
            run_vec(3, a, (a * 5 + 1) & 255, 1, "R4 sbc");
            run_vec(3, a, a, 1, "R4 sbc");
            run_vec(3, a, a, 0, "R4 sbc");
        end
    endtask

    task automatic t_cp();
        for (int a = 0; a < 256; a++) begin
            run_vec(7, a, a, 15, "R5 compare");
            run_vec(7, a, (a * 13 + 9) & 255, 0, "R5 compare");
        end
    endtask

    task automatic t_logic();
        for (int op = 4; op <= 6; op++)
            for (int a = 0; a < 256; a++) begin
                run_vec(op, a, 0, 15, "R6 logic");
                run_vec(op, a, 255, 15, "R6 logic");
                run_vec(op, a, a ^ 8'h5A, 0, "R6 logic");
                run_vec(op, a, 255 - a, 15, "R6 logic");
            end
    endtask

    task automatic t_incdec();
        for (int op = 8; op <= 9; op++)
            for (int b = 0; b < 256; b++) begin
                run_vec(op, 255 - b, b, 0, "R7 inc/dec");
                run_vec(op, b, b, 15, "R7 inc/dec");
                run_vec(op, 0, b, 1, "R7 inc/dec");
                run_vec(op, 170, b, 14, "R7 inc/dec");
            end
    endtask

    task automatic t_daa();
        for (int f = 0; f < 16; f++)
            for (int a = 0; a < 256; a++)
                run_vec(10, a, 8'h33, f, "R8 decimal adjust");
    endtask

    task automatic t_cpl();
        for (int a = 0; a < 256; a++) begin
            run_vec(11, a, 0, 0, "R9 complement");
            run_vec(11, a, 0, 9, "R9 complement");
        end
    endtask

    task automatic t_carry();
        for (int f = 0; f < 16; f++)
            for (int a = 0; a < 256; a += 17) begin
                run_vec(12, a, 0, f, "R10 set carry");
                run_vec(13, a, 0, f, "R10 complement carry");
            end
    endtask

    task automatic t_unused();
        for (int op = 14; op <= 15; op++)
            for (int f = 0; f < 16; f++) begin
                run_vec(op, 0, 8'hFF, f, "R11 unused code");
                run_vec(op, 8'hA5, 8'h5A, f, "R11 unused code");
            end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_add();
        t_sub();
        t_cp();
        t_logic();
        t_incdec();
        t_daa();
        t_cpl();
        t_carry();
        t_unused();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule